// File: doc/BRIEF.md
# Zero-Address Stack Expression Evaluator

This block evaluates arithmetic expressions written as a stream of zero-address instructions. An internal last-in first-out operand stack holds intermediate values. Load and store instructions move words between an external synchronous data memory and the top of the stack. The arithmetic instructions carry no operand addresses at all: each one consumes the two topmost stack words and leaves its single result on top. A sequence such as push A, push B, add, push C, push D, add, multiply, pop X leaves (A+B)·(C+D) at X, and the stack returns to the depth it had before the sequence.

Instructions arrive one at a time over a valid/ready handshake. Every retired instruction produces a one-cycle completion pulse. An instruction that would overrun or underrun the stack is refused, the stack is left untouched, and an error pulse is raised together with the completion pulse.

Top module: `stack_eval`

## Requirements
- R1: After reset, instr_ready is 1 and done, err_overflow, err_underflow, mem_rd_en and mem_wr_en are all 0.
- R2: An accepted load (instr_op 2'b00) on a non-full stack raises mem_rd_en for one cycle, in the cycle after acceptance, with mem_addr equal to instr_addr. The word that memory returns on the following cycle becomes the new top of stack, and done pulses three cycles after acceptance.
- R3: An accepted store (instr_op 2'b01) on a non-empty stack raises mem_wr_en for one cycle, in the cycle after acceptance, with mem_wdata equal to the top word. That word is removed from the stack, and done pulses two cycles after acceptance.
- R4: An add (instr_op 2'b10) with at least two entries replaces them with their sum modulo 2^16 and retires with done one cycle after acceptance.
- R5: A multiply (instr_op 2'b11) with at least two entries replaces them with the low 16 bits of their product and retires with done one cycle after acceptance.
- R6: Stored words come back out in the reverse of the order in which they were loaded.
- R7: A load while 8 words are held raises err_overflow with done one cycle after acceptance, issues no memory read, and leaves the stack unchanged.
- R8: A store on an empty stack, or an add or multiply with fewer than two entries, raises err_underflow with done one cycle after acceptance, issues no memory access, and leaves the stack unchanged.
- R9: instr_ready is 0 from the cycle after a load or store is accepted until that instruction has retired.
- R10: Each accepted instruction produces exactly one done pulse, one cycle long. The error flags are only ever high together with done, and never both at once.
- R11: The sequence push A, push B, add, push C, push D, add, multiply, pop X writes (A+B)·(C+D) to X and restores the original stack depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Evaluator can accept an instruction |
| instr_op | input | 2 | 00 load, 01 store, 10 add, 11 multiply |
| instr_addr | input | 8 | Memory address for load and store |
| mem_addr | output | 8 | Data memory address |
| mem_rd_en | output | 1 | Read strobe, data expected next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd_en |
| done | output | 1 | Instruction retired (one-cycle pulse) |
| err_overflow | output | 1 | Load refused, stack full |
| err_underflow | output | 1 | Store or arithmetic refused, too few entries |

## Verification
The assertions assume that the memory behind the port is synchronous, with read data valid exactly one cycle after the read strobe. They also assume that the instruction fields are stable whenever instr_valid is high. The bench's memory model answers with that fixed latency. It raises instr_valid only while instr_ready is high, drops it right after the accepting edge, and waits for done before issuing the next instruction. Refused instructions are therefore always observed in isolation, with their effect on the stack read back through later stores.

// File: rtl/stkev_pkg.sv
package stkev_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } stk_op_e;

  typedef enum logic [1:0] {
    LF_HOLD,
    LF_PUSH,
    LF_POP,
    LF_MERGE
  } lifo_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_WRITE
  } ctrl_st_e;
endpackage

// File: rtl/stkev_lifo.sv
module stkev_lifo
  import stkev_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  lifo_cmd_e                  cmd,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               tos,
  output logic [W-1:0]               nos,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       two_plus
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     ent [DEPTH];
  logic [DEPTH-1:0] wr_vec;
  logic [AW-1:0]    tos_idx, nos_idx;

  // one write enable per slot: a push fills slot count, a merge rewrites slot count-2
  for (genvar i = 0; i < DEPTH; i++) begin : g_wen
    assign wr_vec[i] = (cmd == LF_PUSH  && count == CW'(i)) ||
                       (cmd == LF_MERGE && count == CW'(i + 2));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (wr_vec[i]) ent[i] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      unique case (cmd)
        LF_PUSH:  count <= count + CW'(1);
        LF_POP,
        LF_MERGE: count <= count - CW'(1);
        default:  count <= count;
      endcase
    end
  end

  assign tos_idx  = AW'(count - CW'(1));
  assign nos_idx  = AW'(count - CW'(2));
  assign tos      = ent[tos_idx];
  assign nos      = ent[nos_idx];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign two_plus = (count >= CW'(2));

  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == LF_PUSH) |-> !full);
  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == LF_POP) |-> !empty);
  a_r8_merge_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == LF_MERGE) |-> two_plus);
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_merge_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == LF_MERGE) |=> (count == $past(count) - CW'(1)));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == LF_PUSH) |=> (count == $past(count) + CW'(1)) && (tos == $past(wdata)));
endmodule

// File: rtl/stkev_alu.sv
module stkev_alu #(
  parameter int W = 16
) (
  input  logic         is_mul,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  function automatic logic [W-1:0] f_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [W-1:0] f_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] wide;
    wide = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return wide[W-1:0];
  endfunction

  assign res = is_mul ? f_prod(opa, opb) : f_sum(opa, opb);
endmodule

// File: rtl/stkev_ctrl.sv
module stkev_ctrl
  import stkev_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [1:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  input  logic          full,
  input  logic          empty,
  input  logic          two_plus,
  output logic          instr_ready,
  output lifo_cmd_e     lifo_cmd,
  output logic          sel_alu,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          done,
  output logic          err_ovf,
  output logic          err_udf
);
  ctrl_st_e      state, state_nx;
  logic [AW-1:0] addr_q;
  stk_op_e       op;

  // named events for the checks below
  logic accept, ev_ovf, ev_udf, ev_retire;

  assign op          = stk_op_e'(instr_op);
  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;

  always_comb begin
    state_nx  = state;
    lifo_cmd  = LF_HOLD;
    sel_alu   = 1'b0;
    ev_ovf    = 1'b0;
    ev_udf    = 1'b0;
    ev_retire = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        unique case (op)
          OP_PUSH: if (full) begin ev_ovf = 1'b1; ev_retire = 1'b1; end
                   else state_nx = ST_READ;
          OP_POP:  if (empty) begin ev_udf = 1'b1; ev_retire = 1'b1; end
                   else state_nx = ST_WRITE;
          default: if (!two_plus) begin ev_udf = 1'b1; ev_retire = 1'b1; end
                   else begin
                     lifo_cmd  = LF_MERGE;
                     sel_alu   = 1'b1;
                     ev_retire = 1'b1;
                   end
        endcase
      end
      ST_READ:  state_nx = ST_CAPT;
      ST_CAPT:  begin lifo_cmd = LF_PUSH; ev_retire = 1'b1; state_nx = ST_IDLE; end
      ST_WRITE: begin lifo_cmd = LF_POP;  ev_retire = 1'b1; state_nx = ST_IDLE; end
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      done    <= 1'b0;
      err_ovf <= 1'b0;
      err_udf <= 1'b0;
    end else begin
      state   <= state_nx;
      done    <= ev_retire;
      err_ovf <= ev_ovf;
      err_udf <= ev_udf;
      if (accept) addr_q <= instr_addr;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd_en = (state == ST_READ);
  assign mem_wr_en = (state == ST_WRITE);

  a_r2_read_follows_push: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PUSH && !full) |=> mem_rd_en && (mem_addr == $past(instr_addr)));
  a_r3_write_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_POP && !empty) |=> mem_wr_en && (mem_addr == $past(instr_addr)));
  a_r2_capture_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (lifo_cmd == LF_PUSH) && !mem_rd_en);
  a_r9_busy_during_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !instr_ready);
  a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf || err_udf) |-> done);
  a_r10_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_ovf, err_udf}));
  a_r7_overflow_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PUSH && full) |=> !mem_rd_en && err_ovf);
endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stkev_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [1:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          done,
  output logic          err_overflow,
  output logic          err_underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  lifo_cmd_e     lcmd;
  logic          sel_alu, full, empty, two_plus;
  logic [W-1:0]  tos, nos, alu_res, lifo_wdata;
  logic [CW-1:0] depth;

  stkev_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_op(instr_op), .instr_addr(instr_addr),
    .full(full), .empty(empty), .two_plus(two_plus),
    .instr_ready(instr_ready), .lifo_cmd(lcmd), .sel_alu(sel_alu),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .done(done), .err_ovf(err_overflow), .err_udf(err_underflow)
  );

  stkev_alu #(.W(W)) u_alu (
    .is_mul(instr_op[0]), .opa(nos), .opb(tos), .res(alu_res)
  );

  assign lifo_wdata = sel_alu ? alu_res : mem_rdata;

  stkev_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .cmd(lcmd), .wdata(lifo_wdata),
    .tos(tos), .nos(nos), .count(depth),
    .full(full), .empty(empty), .two_plus(two_plus)
  );

  assign mem_wdata = tos;

  a_r3_store_data_is_top: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (depth == $past(depth) - CW'(1)));
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> !(mem_rd_en || mem_wr_en));
endmodule

// File: tb/sim_stack_eval.sv
module sim_stack_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_op = 2'b00;
  logic [7:0]  instr_addr = '0;
  logic        instr_ready, mem_rd_en, mem_wr_en, done, err_overflow, err_underflow;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int n_total = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;

  logic [15:0] mem       [256];
  logic [15:0] mem_model [256];
  int          stk [$];

  always #2 clk = ~clk;

  stack_eval u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_rd_en) rd_cnt++;
    if (mem_wr_en) wr_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // issues one instruction, predicts its effect, checks timing, flags and memory
  task automatic run(input logic [1:0] op, input logic [7:0] a, input string tag);
    bit e_ovf, e_udf, is_mem;
    int e_lat, lat, e_rd, e_wr, x, y;
    e_ovf  = (op == 2'b00) && (stk.size() == 8);
    e_udf  = ((op == 2'b01) && (stk.size() == 0)) || (op[1] && (stk.size() < 2));
    is_mem = !e_ovf && !e_udf && !op[1];
    e_lat  = (e_ovf || e_udf || op[1]) ? 1 : (op == 2'b00 ? 3 : 2);
    e_rd   = (op == 2'b00 && !e_ovf) ? 1 : 0;
    e_wr   = (op == 2'b01 && !e_udf) ? 1 : 0;
    if (!e_ovf && !e_udf) begin
      case (op)
        2'b00: stk.push_back(int'(mem_model[a]));
        2'b01: mem_model[a] = 16'(stk.pop_back());
        2'b10: begin y = stk.pop_back(); x = stk.pop_back(); stk.push_back((x + y) & 16'hFFFF); end
        default: begin y = stk.pop_back(); x = stk.pop_back(); stk.push_back((x * y) & 16'hFFFF); end
      endcase
    end
    @(negedge clk);
    chk(instr_ready == 1'b1, "R9", "ready before issue", int'(instr_ready), 1);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    instr_valid = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      if (is_mem) chk(instr_ready == 1'b0, "R9", "ready while busy", int'(instr_ready), 0);
      @(negedge clk);
      lat++;
    end
    chk(lat == e_lat, tag, "done latency", lat, e_lat);
    chk(err_overflow == e_ovf, "R7", "overflow flag", int'(err_overflow), int'(e_ovf));
    chk(err_underflow == e_udf, "R8", "underflow flag", int'(err_underflow), int'(e_udf));
    chk(rd_cnt == e_rd && wr_cnt == e_wr, tag, "memory strobes rd*16+wr",
        rd_cnt * 16 + wr_cnt, e_rd * 16 + e_wr);
    if (e_wr == 1) chk(mem[a] == mem_model[a], tag, "stored word", int'(mem[a]), int'(mem_model[a]));
    @(negedge clk);
    chk(!done && instr_ready, "R10", "done is one cycle, ready back", int'({done, instr_ready}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 37 + 5);
    end
    mem[10] = 16'd3;  mem[11] = 16'd4;  mem[12] = 16'd5;  mem[13] = 16'd6;
    mem[30] = 16'h1234; mem[31] = 16'h0100;
    mem[40] = 16'hFFFF; mem[41] = 16'h0002;
    for (int i = 0; i < 256; i++) mem_model[i] = mem[i];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready && !done && !err_overflow && !err_underflow && !mem_rd_en && !mem_wr_en,
        "R1", "reset outputs", int'({instr_ready, done, err_overflow, err_underflow, mem_rd_en, mem_wr_en}), 32);

    // R11 expression (A+B)*(C+D) -> X, R4 add, R5 multiply
    run(2'b00, 8'd10, "R2"); run(2'b00, 8'd11, "R2"); run(2'b10, 8'd0, "R4");
    run(2'b00, 8'd12, "R2"); run(2'b00, 8'd13, "R2"); run(2'b10, 8'd0, "R4");
    run(2'b11, 8'd0, "R5"); run(2'b01, 8'd20, "R3");
    chk(mem[20] == 16'd77, "R11", "expression result", int'(mem[20]), 77);
    run(2'b01, 8'd21, "R11");   // depth restored: store on empty stack underflows

    // R5 truncation and R4 wrap
    run(2'b00, 8'd30, "R2"); run(2'b00, 8'd31, "R2"); run(2'b11, 8'd0, "R5"); run(2'b01, 8'd32, "R5");
    chk(mem[32] == 16'h3400, "R5", "product low half", int'(mem[32]), 16'h3400);
    run(2'b00, 8'd40, "R2"); run(2'b00, 8'd41, "R2"); run(2'b10, 8'd0, "R4"); run(2'b01, 8'd42, "R4");
    chk(mem[42] == 16'h0001, "R4", "sum wraps", int'(mem[42]), 1);

    // R8 refused arithmetic leaves the single entry intact
    run(2'b00, 8'd10, "R2"); run(2'b10, 8'd0, "R8"); run(2'b11, 8'd0, "R8"); run(2'b01, 8'd50, "R8");
    chk(mem[50] == 16'd3, "R8", "entry untouched", int'(mem[50]), 3);

    // R7 overflow and R6 reverse order
    for (int i = 0; i < 9; i++) run(2'b00, 8'(60 + i), i == 8 ? "R7" : "R2");
    for (int i = 0; i < 8; i++) run(2'b01, 8'(70 + i), "R6");
    chk(mem[70] == mem[67] && mem[77] == mem[60], "R6", "reverse order", int'(mem[70]), int'(mem[67]));
    run(2'b01, 8'd78, "R8");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule